// File: doc/BRIEF.md
# Masked Vector Element Shift Unit

This block applies a single-width shift to every element of a vector register one element per clock. The element width is 8, 16, 32 or 64 bits. The shift can be a logical left shift, a logical right shift or an arithmetic right shift. The shifted operand always comes from the second source vector. The shift amount comes from the matching element of the first source vector or from one scalar that is shared by all elements.

A start pulse latches every operand and setting. The unit then walks over all element slots of the register. Slots below the active length are computed, unless masking is on and the slot's mask bit is clear; in that case the slot keeps the old destination value. Slots from the active length up to the register's element capacity are written with zero. A one-cycle done pulse marks the point where the whole destination image on `vd_out` is final.

Top module: `vshift_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `vd_out` is all zeros.
- R2: Element i occupies bits [i*SEW +: SEW] of each register. `sew` selects SEW: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. The element capacity is VLEN/SEW.
- R3: `op` = 0 shifts the vs2 element left and fills with zeros. Bits shifted past SEW are lost.
- R4: `op` = 1 shifts the vs2 element right as an unsigned value.
- R5: `op` = 2 or 3 shifts the vs2 element right as a signed value and copies its top bit into the vacated positions.
- R6: Only the low log2(SEW) bits of the shift amount are used: 3, 4, 5 or 6 bits.
- R7: With `scalar_form` = 0, element i's amount is element i of `vs1`. With `scalar_form` = 1, every element uses `scalar`.
- R8: With `vm` = 0, an element whose mask bit is 0 keeps its `vd_in` value. With `vm` = 1, the mask register is ignored.
- R9: Element i's mask bit is bit i*`mstride` of `vmask`. It reads as 0 when that position is at or above VLEN.
- R10: Every element with an index from the clamped `vl` up to the capacity minus one is written as zero, whatever its mask bit.
- R11: A `vl` above the element capacity is treated as the capacity.
- R12: `done` pulses high for one cycle exactly VLEN/SEW rising edges after the edge that accepts `start`. `busy` is high from the accept edge until `done` rises. `vd_out` does not change while the unit is idle.
- R13: A `start` pulse that arrives while `busy` is high is ignored. A `start` in the same cycle as `done` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latch operands and begin an operation |
| sew | input | 2 | Element width code |
| op | input | 2 | Shift kind |
| scalar_form | input | 1 | 1: the shift amount comes from `scalar` |
| vm | input | 1 | 0: masking is enabled |
| mstride | input | $clog2(VLEN)+1 | Mask bit stride per element |
| vl | input | $clog2(VLEN/8)+2 | Active element count |
| scalar | input | 64 | Broadcast shift amount |
| vd_in | input | VLEN | Old destination register |
| vs1 | input | VLEN | Per-element shift amounts |
| vs2 | input | VLEN | Elements to be shifted |
| vmask | input | VLEN | Mask register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| vd_out | output | VLEN | Destination register image |

## Verification
The completion pulse of one operation and the acceptance of the next `start` can fall in the same cycle. The bench launches each new operation in the cycle where `done` is seen, so every run after the first starts back to back. Each such run is judged on two things: its own cycle count to `done`, and a result that is exact with no trace of the previous operands. A second overlap is also provoked: a `start` carrying different operands is pushed in while the unit is busy. That run must finish on its original schedule with its original result.

// File: rtl/vshift_unit.sv
module vshift_unit #(
  parameter int VLEN = 256,
  localparam int MAXE = VLEN / 8,
  localparam int IW = $clog2(MAXE),
  localparam int VLW = IW + 2,
  localparam int MLW = $clog2(VLEN) + 1,
  localparam int SHW = $clog2(VLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      sew,
  input  logic [1:0]      op,
  input  logic            scalar_form,
  input  logic            vm,
  input  logic [MLW-1:0]  mstride,
  input  logic [VLW-1:0]  vl,
  input  logic [63:0]     scalar,
  input  logic [VLEN-1:0] vd_in,
  input  logic [VLEN-1:0] vs1,
  input  logic [VLEN-1:0] vs2,
  input  logic [VLEN-1:0] vmask,
  output logic            busy,
  output logic            done,
  output logic [VLEN-1:0] vd_out
);

  logic [VLEN-1:0] res, s1_r, s2_r, m_r;
  logic [63:0]     sc_r;
  logic [1:0]      sew_r, op_r;
  logic            form_r, vm_r;
  logic [MLW-1:0]  ml_r;
  logic [VLW-1:0]  vl_r;
  logic [IW-1:0]   idx;

  logic [VLW-1:0]  cap_in, cap_r;
  assign cap_in = VLW'(MAXE) >> sew;
  assign cap_r  = VLW'(MAXE) >> sew_r;

  logic last;
  assign last = VLW'(idx) == cap_r - VLW'(1);

  logic [6:0]      esz;
  logic [63:0]     emask;
  logic [SHW-1:0]  off;
  assign esz   = 7'd8 << sew_r;
  assign emask = (sew_r == 2'd3) ? '1 : ((64'd1 << esz) - 64'd1);
  assign off   = SHW'({idx, 3'b000}) << sew_r;

  logic [VLEN-1:0] s2sh, s1sh;
  logic [63:0]     a_raw, a_sx, shv, wval;
  logic [5:0]      amt;
  logic            sgn;
  assign s2sh  = s2_r >> off;
  assign s1sh  = s1_r >> off;
  assign a_raw = s2sh[63:0] & emask;
  assign amt   = (form_r ? sc_r[5:0] : s1sh[5:0]) & (esz[5:0] - 6'd1);
  assign sgn   = a_raw[6'(esz - 7'd1)];
  assign a_sx  = sgn ? (a_raw | ~emask) : a_raw;

  always_comb begin
    case (op_r)
      2'd0:    shv = a_raw << amt;
      2'd1:    shv = a_raw >> amt;
      default: shv = 64'($signed(a_sx) >>> amt);
    endcase
  end

  logic [IW+MLW-1:0] mpos;
  logic [VLEN-1:0]   msh;
  logic              mbit, active, wr;
  assign mpos   = (IW+MLW)'(idx) * (IW+MLW)'(ml_r);
  assign msh    = m_r >> mpos;
  assign mbit   = msh[0];
  assign active = VLW'(idx) < vl_r;
  assign wr     = !active || vm_r || mbit;
  assign wval   = active ? (shv & emask) : 64'd0;

  logic [VLEN-1:0] fmask, res_next;
  assign fmask    = VLEN'(emask) << off;
  assign res_next = (res & ~fmask) | (VLEN'(wval) << off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0; s1_r <= '0; s2_r <= '0; m_r <= '0; sc_r <= '0;
      sew_r <= '0; op_r <= '0; form_r <= 1'b0; vm_r <= 1'b1;
      ml_r <= '0; vl_r <= '0; idx <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (wr) res <= res_next;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + IW'(1);
        end
      end else if (start) begin
        res <= vd_in; s1_r <= vs1; s2_r <= vs2; m_r <= vmask; sc_r <= scalar;
        sew_r <= sew; op_r <= op; form_r <= scalar_form; vm_r <= vm;
        ml_r <= mstride; vl_r <= (vl > cap_in) ? cap_in : vl;
        idx <= '0; busy <= 1'b1;
      end
    end
  end

  assign vd_out = res;

endmodule

// File: rtl/vshift_unit_chk.sv
module vshift_unit_chk #(
  parameter int VLEN = 256,
  localparam int IW = $clog2(VLEN / 8)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            vm_q,
  input logic            mbit,
  input logic            active,
  input logic            last,
  input logic [IW-1:0]   idx,
  input logic [VLEN-1:0] vd_out
);

  a_r12_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(vd_out));

  a_r13_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> (busy && idx == $past(idx) + IW'(1)));

  a_r8_masked_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && active && !vm_q && !mbit) |=> $stable(vd_out));

  a_r12_busy_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

endmodule

bind vshift_unit vshift_unit_chk #(.VLEN(VLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .vm_q(vm_r), .mbit(mbit), .active(active), .last(last), .idx(idx),
  .vd_out(vd_out)
);

// File: tb/sim_vshift_unit.sv
`timescale 1ns/1ps
module sim_vshift_unit;
  localparam int VL = 64;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] sew = 0, op = 0;
  logic scalar_form = 0, vm = 1;
  logic [6:0] mstride = 1;
  logic [4:0] vl = 0;
  logic [63:0] scalar = 0, vd_in = 0, vs1 = 0, vs2 = 0, vmask = 0;
  logic busy, done;
  logic [63:0] vd_out;

  int n_chk = 0, n_fail = 0;
  logic [63:0] expv;
  int exp_cyc;

  always #2.5 clk = ~clk;

  vshift_unit #(.VLEN(VL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sew(sew), .op(op),
    .scalar_form(scalar_form), .vm(vm), .mstride(mstride), .vl(vl),
    .scalar(scalar), .vd_in(vd_in), .vs1(vs1), .vs2(vs2), .vmask(vmask),
    .busy(busy), .done(done), .vd_out(vd_out));

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exv);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] d, a1, a2, mk, sc,
      input int sw, o, fm, vmi, ml, vli);
    int esz, me, ve, amt, mp;
    logic [127:0] em, a, b, v;
    logic [63:0] r;
    esz = 8 << sw; me = 64 / esz; ve = (vli > me) ? me : vli;
    em = (128'd1 << esz) - 1; r = d;
    for (int i = 0; i < me; i++) begin
      mp = i * ml;
      if (i >= ve) v = 0;
      else begin
        if (vmi == 0 && !(mp < 64 && mk[mp])) continue;
        a = (128'(a2) >> (i * esz)) & em;
        b = (128'(a1) >> (i * esz)) & em;
        amt = int'(fm ? sc[5:0] : b[5:0]) % esz;
        if (o == 0) v = (a << amt) & em;
        else if (o == 1) v = a >> amt;
        else v = (a >> amt) | (((a >> (esz - 1)) & 1) != 0 ? (em ^ (em >> amt)) : 128'd0);
      end
      r = (r & ~64'(em << (i * esz))) | 64'(v << (i * esz));
    end
    return r;
  endfunction

  task automatic launch(input logic [63:0] d, a1, a2, mk, sc,
      input int sw, o, fm, vmi, ml, vli);
    vd_in = d; vs1 = a1; vs2 = a2; vmask = mk; scalar = sc;
    sew = 2'(sw); op = 2'(o); scalar_form = fm[0]; vm = vmi[0];
    mstride = 7'(ml); vl = 5'(vli);
    expv = model(d, a1, a2, mk, sc, sw, o, fm, vmi, ml, vli);
    exp_cyc = VL / (8 << sw);
    start = 1'b1;
  endtask

  task automatic finish(input string tag, input bit poke);
    int n;
    n = 0;
    @(posedge clk); #1;
    start = 1'b0;
    while (!done && n < 100) begin
      if (poke && n == 1 && busy) begin
        start = 1'b1; vd_in = ~vd_in; vs2 = ~vs2;
      end else start = 1'b0;
      @(posedge clk); #1; n++;
    end
    start = 1'b0;
    check(n == exp_cyc, {tag, " R12 cycles to done"}, 64'(n), 64'(exp_cyc));
    check(vd_out == expv, {tag, " result"}, vd_out, expv);
  endtask

  initial begin
    #750000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(busy == 0 && done == 0, "R1 reset flags", {62'd0, busy, done}, 64'd0);
    check(vd_out == 0, "R1 reset data", vd_out, 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R5: 8-bit element 0x80 arithmetic right by 3 gives 0xF0; tail zeroed (R10)
    launch(64'hFFFF_FFFF_FFFF_FFFF, 0, 64'h80, 0, 3, 0, 2, 1, 1, 1, 1);
    finish("R5 R10 directed", 0);
    check(vd_out == 64'hF0, "R5 sign fill", vd_out, 64'hF0);
    // R6: amount 9 on 8-bit acts as 1; R3 drops carried-out bit
    launch(0, 0, 64'h81, 0, 9, 0, 0, 1, 1, 1, 1);
    finish("R6 R3 directed", 0);
    check(vd_out == 64'h02, "R6 truncated amount", vd_out, 64'h02);
    // R7 R2: per-element amounts in 16-bit lanes
    launch(0, 64'h0003_0002_0001_0000, 64'h0001_0001_0001_0001, 0, 0, 1, 0, 0, 1, 1, 4);
    finish("R7 R2 directed", 0);
    check(vd_out == 64'h0008_0004_0002_0001, "R7 R2 lane amounts", vd_out, 64'h0008_0004_0002_0001);
    // R4: logical right keeps zeros on top of 32-bit lane
    launch(0, 0, 64'h8000_0000_8000_0000, 0, 4, 2, 1, 1, 1, 1, 2);
    finish("R4 directed", 0);
    check(vd_out == 64'h0800_0000_0800_0000, "R4 zero fill", vd_out, 64'h0800_0000_0800_0000);
    // R8 R9: stride 2, mask bits 0 and 4 set -> elements 0 and 2 written
    launch(64'hAAAA_AAAA_AAAA_AAAA, 0, 64'h1111_1111_1111_1111, 64'h11, 1, 0, 0, 1, 0, 2, 8);
    finish("R8 R9 directed", 0);
    check(vd_out == 64'hAAAA_AAAA_AA22_AA22, "R9 strided mask", vd_out, 64'hAAAA_AAAA_AA22_AA22);

    // Sweep: R3 R4 R5 R7 R8 R9 R10 R11, each launch back to back with done (R13)
    for (int sw = 0; sw < 4; sw++)
      for (int o = 0; o < 3; o++)
        for (int fm = 0; fm < 2; fm++)
          for (int vi = 0; vi < 5; vi++)
            for (int vmi = 0; vmi < 2; vmi++)
              for (int ml = 1; ml < 4; ml += 2) begin
                int vli;
                vli = (vi == 0) ? 0 : (vi == 1) ? 1 : (vi == 2) ? 3 :
                      (vi == 3) ? VL / (8 << sw) : 31;
                launch({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                       {$urandom, $urandom}, {$urandom, $urandom}, sw, o, fm, vmi, ml, vli);
                finish(o == 0 ? "R3 R7 R8 R9 R10 R11 R13 sweep" :
                       o == 1 ? "R4 R7 R8 R9 R10 R11 R13 sweep" :
                                "R5 R7 R8 R9 R10 R11 R13 sweep", (vi == 4) && (sw < 3));
              end

    // R13: op code 3 behaves as arithmetic right, with start poked while busy
    launch(0, 0, 64'h8000_8000_8000_8000, 0, 15, 1, 3, 1, 1, 1, 4);
    finish("R13 R5 busy start", 1);
    check(vd_out == 64'hFFFF_FFFF_FFFF_FFFF, "R5 op3 full fill", vd_out, 64'hFFFF_FFFF_FFFF_FFFF);

    // R12: done lasts one cycle; idle output stays put
    @(posedge clk); #1;
    check(done == 0 && busy == 0, "R12 done single cycle", {62'd0, busy, done}, 64'd0);
    vd_in = 64'h1234; vs2 = 64'h5678;
    repeat (3) @(posedge clk);
    #1;
    check(vd_out == 64'hFFFF_FFFF_FFFF_FFFF, "R12 idle hold", vd_out, 64'hFFFF_FFFF_FFFF_FFFF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule